// File: doc/BRIEF.md
# Depth-Ordered Store Commit Unit

This block sits in front of a memory partition and merges buffered stores that reach it in any order from many wavefronts. Every store carries a location address, a data word and a depth tag, which is the ID of the wavefront that issued it. The block keeps a depth and a value for each location. A store replaces both only when its depth is strictly below the depth already held. The surviving value of each location is therefore fixed by the tags and does not depend on the order in which the stores arrive.

Software-visible behaviour comes in commit windows. A `begin_i` pulse opens a window, and the block then accepts stores. An `end_i` pulse closes the window. The block lets its two-stage compare-and-update pipeline empty, then sweeps the whole table in ascending address order. For each location that a store touched, it emits one final write toward the backing memory. It resets every depth entry to infinity (the all-ones code) during the same sweep. `busy_o` stays high from the close of the window until the sweep ends. No new window can open while it is high.

Top module: `depth_commit`

## Requirements
- R1: After reset, `st_ready_o`, `busy_o` and `wr_en_o` are all 0.
- R2: A `begin_i` pulse while idle and not busy opens a window, and `st_ready_o` is 1 from the next cycle.
- R3: For one location, a store with a lower depth tag wins over one with a higher tag that is accepted after it. The final write carries the lower-tag data.
- R4: A store with a lower depth tag that is accepted after a higher-tag store to the same location replaces it. The final write carries the lower-tag data, so the result is the same for either arrival order.
- R5: When two stores to one location carry equal depth tags, the one accepted first is kept.
- R6: Stores to the same location accepted on consecutive cycles resolve exactly as they would if they were spaced apart.
- R7: An `end_i` pulse in an open window sets `st_ready_o` to 0 from the next cycle. The block then emits exactly one write per touched location, in strictly ascending address order, and none for untouched locations, while `busy_o` is 1.
- R8: Each commit starts from a table whose depths are all infinity (all ones). A store of any tag below that code to a location committed earlier takes effect.
- R9: A store presented while `st_ready_o` is 0 is dropped and produces no write.
- R10: A `begin_i` pulse while `busy_o` is 1 has no effect, and `st_ready_o` stays 0 after the sweep ends.
- R11: `wr_en_o` is 1 only while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| begin_i | input | 1 | open a commit window (pulse) |
| end_i | input | 1 | close the window and start the drain (pulse) |
| st_valid_i | input | 1 | store present |
| st_addr_i | input | ADDR_W | store location |
| st_data_i | input | DATA_W | store data |
| st_depth_i | input | DEPTH_W | depth tag (issuing wavefront ID) |
| st_ready_o | output | 1 | store accepted this cycle when valid |
| busy_o | output | 1 | drain and clear in progress |
| wr_en_o | output | 1 | final write strobe |
| wr_addr_o | output | ADDR_W | final write location |
| wr_data_o | output | DATA_W | final write data |

## Verification
The low-tag-wins rule is checked with both arrival orders. One location gets its winner first and a later loser, and another gets the loser first and a later winner. A mismatch in either case points to a wrong comparison direction rather than an ordering effect. Equal-tag pairs separate strict from non-strict comparison. Same-address stores on consecutive cycles expose a missing forward between the read and write stages, which spaced stores would hide. A second commit reuses an address at a large tag to show that the previous sweep cleared the depth table. Stores offered while the window is closed, and a `begin_i` pulse during the sweep, show up as stray writes or a stray ready.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OPEN  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_SWEEP = 2'd3
  } dc_state_e;
endpackage

// File: rtl/dc_table.sv
module dc_table #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int DEPTH_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_en_i,
  input  logic [ADDR_W-1:0]  upd_addr_i,
  input  logic [DATA_W-1:0]  upd_data_i,
  input  logic [DEPTH_W-1:0] upd_depth_i,
  input  logic               clr_en_i,
  input  logic [ADDR_W-1:0]  clr_idx_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DEPTH_W-1:0] rd_depth_o,
  output logic [DEPTH_W-1:0] sw_depth_o,
  output logic [DATA_W-1:0]  sw_data_o
);
  localparam int N = 1 << ADDR_W;
  localparam logic [DEPTH_W-1:0] INF = '1;

  logic [DEPTH_W-1:0] dep_q [N];
  logic [DATA_W-1:0]  dat_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic hit_clr, hit_upd;
    assign hit_clr = clr_en_i && (clr_idx_i == ADDR_W'(g));
    assign hit_upd = upd_en_i && (upd_addr_i == ADDR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      dep_q[g] <= INF;
      else if (hit_clr) dep_q[g] <= INF;
      else if (hit_upd) dep_q[g] <= upd_depth_i;
    end

    always_ff @(posedge clk_i) begin
      if (hit_upd) dat_q[g] <= upd_data_i;
    end
  end

  assign rd_depth_o = dep_q[rd_addr_i];
  assign sw_depth_o = dep_q[clr_idx_i];
  assign sw_data_o  = dat_q[clr_idx_i];
endmodule

// File: rtl/dc_pipe.sv
module dc_pipe #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int DEPTH_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic [DEPTH_W-1:0] rd_depth_i,
  output logic               upd_en_o,
  output logic [ADDR_W-1:0]  upd_addr_o,
  output logic [DATA_W-1:0]  upd_data_o,
  output logic [DEPTH_W-1:0] upd_depth_o,
  output logic               empty_o
);
  // stage 1: capture + table read; stage 2: compare + write
  logic               p1_v, p2_v;
  logic [ADDR_W-1:0]  p1_addr, p2_addr;
  logic [DATA_W-1:0]  p1_data, p2_data;
  logic [DEPTH_W-1:0] p1_dep, p2_dep, p2_old;
  logic               p2_win, fwd;
  logic [DEPTH_W-1:0] old_nxt;

  assign p2_win  = p2_v && (p2_dep < p2_old);
  // stage 2 writes this edge; the stage 1 read still sees the stale entry
  assign fwd     = p2_win && (p2_addr == p1_addr);
  assign old_nxt = fwd ? p2_dep : rd_depth_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_v <= 1'b0;
      p2_v <= 1'b0;
    end else begin
      p1_v <= acc_i;
      p2_v <= p1_v;
    end
  end

  always_ff @(posedge clk_i) begin
    if (acc_i) begin
      p1_addr <= addr_i;
      p1_data <= data_i;
      p1_dep  <= depth_i;
    end
    if (p1_v) begin
      p2_addr <= p1_addr;
      p2_data <= p1_data;
      p2_dep  <= p1_dep;
      p2_old  <= old_nxt;
    end
  end

  assign rd_addr_o   = p1_addr;
  assign upd_en_o    = p2_win;
  assign upd_addr_o  = p2_addr;
  assign upd_data_o  = p2_data;
  assign upd_depth_o = p2_dep;
  assign empty_o     = !p1_v && !p2_v;
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              begin_i,
  input  logic              end_i,
  input  logic              pipe_empty_i,
  output dc_state_e         state_o,
  output logic              sweep_en_o,
  output logic [ADDR_W-1:0] sweep_idx_o
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  dc_state_e         st_q, st_d;
  logic [ADDR_W-1:0] idx_q, idx_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_IDLE:  if (begin_i) st_d = ST_OPEN;
      ST_OPEN:  if (end_i) st_d = ST_FLUSH;
      ST_FLUSH: if (pipe_empty_i) begin
        st_d  = ST_SWEEP;
        idx_d = '0;
      end
      ST_SWEEP: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST) st_d = ST_IDLE;
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign state_o     = st_q;
  assign sweep_en_o  = (st_q == ST_SWEEP);
  assign sweep_idx_o = idx_q;
endmodule

// File: rtl/depth_commit.sv
module depth_commit
  import dc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int NUM_WF = 48,
  localparam int DEPTH_W = $clog2(NUM_WF + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               begin_i,
  input  logic               end_i,
  input  logic               st_valid_i,
  input  logic [ADDR_W-1:0]  st_addr_i,
  input  logic [DATA_W-1:0]  st_data_i,
  input  logic [DEPTH_W-1:0] st_depth_i,
  output logic               st_ready_o,
  output logic               busy_o,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o
);
  localparam logic [DEPTH_W-1:0] INF = '1;

  dc_state_e          state;
  logic               acc, pipe_empty, sweep_en;
  logic [ADDR_W-1:0]  sweep_idx, rd_addr, upd_addr;
  logic [DEPTH_W-1:0] rd_depth, upd_depth, sw_depth;
  logic [DATA_W-1:0]  upd_data, sw_data;
  logic               upd_en;

  assign st_ready_o = (state == ST_OPEN);
  assign acc        = st_valid_i && st_ready_o;

  dc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .begin_i, .end_i,
    .pipe_empty_i(pipe_empty),
    .state_o(state),
    .sweep_en_o(sweep_en),
    .sweep_idx_o(sweep_idx)
  );

  dc_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH_W(DEPTH_W)) u_pipe (
    .clk_i, .rst_ni,
    .acc_i(acc),
    .addr_i(st_addr_i),
    .data_i(st_data_i),
    .depth_i(st_depth_i),
    .rd_addr_o(rd_addr),
    .rd_depth_i(rd_depth),
    .upd_en_o(upd_en),
    .upd_addr_o(upd_addr),
    .upd_data_o(upd_data),
    .upd_depth_o(upd_depth),
    .empty_o(pipe_empty)
  );

  dc_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH_W(DEPTH_W)) u_tab (
    .clk_i, .rst_ni,
    .upd_en_i(upd_en),
    .upd_addr_i(upd_addr),
    .upd_data_i(upd_data),
    .upd_depth_i(upd_depth),
    .clr_en_i(sweep_en),
    .clr_idx_i(sweep_idx),
    .rd_addr_i(rd_addr),
    .rd_depth_o(rd_depth),
    .sw_depth_o(sw_depth),
    .sw_data_o(sw_data)
  );

  assign busy_o    = (state == ST_FLUSH) || (state == ST_SWEEP);
  assign wr_en_o   = sweep_en && (sw_depth != INF);
  assign wr_addr_o = sweep_idx;
  assign wr_data_o = sw_data;
endmodule

// File: rtl/depth_commit_chk.sv
module depth_commit_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              begin_i,
  input logic              end_i,
  input logic              st_ready_o,
  input logic              busy_o,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o
);
  AST_BUSY_BLOCKS_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !st_ready_o); // R9

  AST_WR_INSIDE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o); // R11

  AST_WR_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o > $past(wr_addr_o))); // R7

  AST_END_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_ready_o && end_i) |=> !st_ready_o); // R7

  AST_BEGIN_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && begin_i) |=> !st_ready_o); // R10

  AST_BEGIN_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !st_ready_o && begin_i) |=> st_ready_o); // R2
endmodule

bind depth_commit depth_commit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .begin_i, .end_i, .st_ready_o, .busy_o, .wr_en_o, .wr_addr_o
);

// File: tb/depth_commit_bench.sv
module depth_commit_bench;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int NUM_WF = 48;
  localparam int DEPTH_W = $clog2(NUM_WF + 1);
  localparam int N = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic begin_i = 1'b0, end_i = 1'b0, st_valid_i = 1'b0;
  logic [ADDR_W-1:0]  st_addr_i = '0;
  logic [DATA_W-1:0]  st_data_i = '0;
  logic [DEPTH_W-1:0] st_depth_i = '0;
  logic st_ready_o, busy_o, wr_en_o;
  logic [ADDR_W-1:0] wr_addr_o;
  logic [DATA_W-1:0] wr_data_o;

  always #2.5 clk = ~clk;

  depth_commit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WF(NUM_WF)) u_depth_commit (
    .clk_i(clk), .rst_ni, .begin_i, .end_i, .st_valid_i, .st_addr_i, .st_data_i,
    .st_depth_i, .st_ready_o, .busy_o, .wr_en_o, .wr_addr_o, .wr_data_o
  );

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic [ADDR_W-1:0] a; logic [DATA_W-1:0] d; } exp_t;
  exp_t exp_q[$];
  bit                 m_set [N];
  logic [DEPTH_W-1:0] m_dep [N];
  logic [DATA_W-1:0]  m_dat [N];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic send(input int a, input int d, input int dep);
    @(negedge clk);
    st_valid_i = 1'b1;
    st_addr_i  = ADDR_W'(a);
    st_data_i  = DATA_W'(d);
    st_depth_i = DEPTH_W'(dep);
    if (st_ready_o && (!m_set[a] || DEPTH_W'(dep) < m_dep[a])) begin
      m_set[a] = 1'b1; m_dep[a] = DEPTH_W'(dep); m_dat[a] = DATA_W'(d);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      st_valid_i = 1'b0;
    end
  endtask

  task automatic open_window();
    @(negedge clk); begin_i = 1'b1;
    @(negedge clk); begin_i = 1'b0;
    chk(st_ready_o == 1'b1, "R2", "ready after begin", st_ready_o, 1);
  endtask

  task automatic close_window();
    for (int a = 0; a < N; a++)
      if (m_set[a]) exp_q.push_back('{a: ADDR_W'(a), d: m_dat[a]});
    @(negedge clk); st_valid_i = 1'b0; end_i = 1'b1;
    @(negedge clk); end_i = 1'b0;
    chk(st_ready_o == 1'b0, "R7", "ready after end", st_ready_o, 0);
    chk(busy_o == 1'b1, "R7", "busy after end", busy_o, 1);
    while (busy_o) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "writes missing", exp_q.size(), 0);
    exp_q.delete();
    for (int a = 0; a < N; a++) m_set[a] = 1'b0;
  endtask

  // monitor: every write must match the head of the expected queue
  always @(negedge clk) begin
    if (rst_ni && wr_en_o) begin
      chk(busy_o == 1'b1, "R11", "write outside busy", busy_o, 1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7/R9", "unexpected write addr", wr_addr_o, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(wr_addr_o == e.a, "R7", "write addr", wr_addr_o, e.a);
        chk(wr_data_o == e.d, "R3/R4/R5/R6/R8", "write data", wr_data_o, e.d);
      end
    end
  end

  initial begin
    for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
    if (!done) begin
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < N; a++) m_set[a] = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(st_ready_o == 1'b0, "R1", "reset ready", st_ready_o, 0);
    chk(busy_o == 1'b0, "R1", "reset busy", busy_o, 0);
    chk(wr_en_o == 1'b0, "R1", "reset wr_en", wr_en_o, 0);
    rst_ni = 1'b1;
    idle(2);

    // commit 1
    open_window();
    send(5, 6, 0); idle(3); send(5, 2, 1); idle(3);        // R3: winner first
    send(9, 2, 2); idle(3); send(9, 7, 1); idle(3);        // R4: winner last
    send(12, 11, 3); idle(3); send(12, 22, 3); idle(3);    // R5: equal tags
    send(20, 100, 5); send(20, 200, 4); send(20, 300, 6);  // R6: back-to-back
    send(21, 1, 7); send(21, 2, 7);                        // R5/R6 equal, back-to-back
    send(40, 10, 9); send(40, 20, 8); send(40, 30, 2);     // R6 descending chain
    idle(1);
    close_window();

    // R9: stores while closed
    send(30, 99, 0); send(31, 98, 1); idle(4);
    chk(wr_en_o == 1'b0, "R9", "no write while idle", wr_en_o, 0);

    // commit 2
    open_window();
    send(5, 2, 1); idle(2); send(5, 6, 0); idle(2);        // R3/R4 reversed order
    send(9, 85, 40); idle(2);                              // R8: cleared table
    send(63, 7, NUM_WF - 1); send(0, 8, 0); idle(2);
    for (int a = 0; a < N; a++) exp_q.push_back('{a: 0, d: 0});
    exp_q.delete();
    // close with a begin pulse during the sweep (R10)
    for (int a = 0; a < N; a++)
      if (m_set[a]) exp_q.push_back('{a: ADDR_W'(a), d: m_dat[a]});
    @(negedge clk); end_i = 1'b1;
    @(negedge clk); end_i = 1'b0;
    repeat (10) @(negedge clk);
    begin_i = 1'b1;
    @(negedge clk); begin_i = 1'b0;
    chk(st_ready_o == 1'b0, "R10", "ready during busy", st_ready_o, 0);
    while (busy_o) @(negedge clk);
    idle(3);
    chk(st_ready_o == 1'b0, "R10", "ready after sweep", st_ready_o, 0);
    chk(exp_q.size() == 0, "R7", "writes missing", exp_q.size(), 0);
    exp_q.delete();
    for (int a = 0; a < N; a++) m_set[a] = 1'b0;

    // commit 3: a plain second window still works after R10
    open_window();
    send(33, 5, 3); send(33, 4, 3);
    idle(1);
    close_window();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule